// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a countdown watchdog that tolerates one missed service before it takes the system down. A tick input, whose period is set outside the block, drives a down-counter. When the counter runs out for the first time, a timeout flag is set and the counter reloads. The flag can raise a management interrupt, but only when both a local watchdog enable and a global interrupt enable are set. If the counter runs out a second time while the flag is still set, the block drives a fixed-length system reset pulse. After the pulse, the counter and the flag return to their power-on values.

Software uses a small register port to control the block. Through it, software can halt the countdown, clear the flag, program the reload value, set the two interrupt enables and kick the timer. Clearing the flag between the two expiries prevents the reset. The longest hang before a reset is therefore close to two periods, and the shortest is just over one period.

Top module: `dual_expiry_wdt`

## Requirements
- R1: The counter starts at RELOAD_INIT. On each tick with halt clear, it decrements when it is nonzero. On a tick that finds it at zero, an expiry occurs and the counter loads the reload register. A full period is therefore reload+1 ticks.
- R2: An expiry while the timeout flag (status word bit 0) is clear sets the flag and does not assert the reset.
- R3: An expiry while the flag is set raises `sys_reset` on the next clock edge. `sys_reset` then stays high for exactly RST_LEN (default 16) cycles.
- R4: On the cycle that `sys_reset` falls, the counter returns to RELOAD_INIT and the flag returns to 0.
- R5: Writing the status word with bit 0 set clears the flag. Writing bit 0 as 0 leaves the flag unchanged. A flag cleared before the next expiry prevents the reset.
- R6: `mgmt_irq` equals, one cycle late, the flag ANDed with bit 13 (local enable) and bit 0 (global enable) of the interrupt-enable word.
- R7: While bit 11 of the control word is set, ticks do not change the counter.
- R8: Any write to address 4 (kick) reloads the counter from the reload register. A kick takes priority over a tick in the same cycle, and it also works while the counter is halted.
- R9: `reg_rdata` shows, one cycle after `reg_addr` is presented, the word at that address: 0 control, 1 status (flag in bit 0), 2 reload, 3 interrupt enable, 5 live count. Addresses 4, 6 and 7 read as zero.
- R10: While `sys_reset` is high, the counter is frozen, and kick writes and flag-clear writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle countdown enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mgmt_irq | output | 1 | Management interrupt (level) |
| sys_reset | output | 1 | System reset pulse |

## Verification
Register writes take effect at the clock edge that samples them. The flag and the counter therefore move at that edge, while `mgmt_irq` and `reg_rdata` follow one edge later and `sys_reset` rises at the edge after the expiring tick. A behavioural model in the bench steps at each rising edge from its own state and from the inputs that were driven. It compares the interrupt, the reset and the read data at the following falling edge, so every comparison falls in the cycle where the result is due. Directed sequences add checks on pulse length, flag clearing, halting, kicking and the effects that are suppressed during the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 32;
  localparam int HALT_BIT   = 11;
  localparam int LOC_EN_BIT = 13;
  localparam int GLB_EN_BIT = 0;
  localparam int FLAG_BIT   = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_RELOAD = 3'd2,
    A_IEN    = 3'd3,
    A_KICK   = 3'd4,
    A_COUNT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RELOAD_INIT = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  input  logic [CNT_W-1:0]  count,
  input  logic              pulsing,
  output logic              halt,
  output logic              loc_en,
  output logic              glb_en,
  output logic [CNT_W-1:0]  reload,
  output logic              kick,
  output logic              clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ien_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      reload_q <= CNT_W'(RELOAD_INIT);
    end else if (wr) begin
      case (addr)
        A_CTRL:   ctrl_q   <= wdata;
        A_IEN:    ien_q    <= wdata;
        A_RELOAD: reload_q <= wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    kick = wr && (addr == A_KICK) && !pulsing;
    clr  = wr && (addr == A_STAT) && wdata[FLAG_BIT] && !pulsing;
  end

  assign halt   = ctrl_q[HALT_BIT];
  assign loc_en = ien_q[LOC_EN_BIT];
  assign glb_en = ien_q[GLB_EN_BIT];
  assign reload = reload_q;

  always_comb begin
    case (addr)
      A_CTRL:   rd_mux = ctrl_q;
      A_STAT:   rd_mux = {{(DATA_W-1){1'b0}}, flag};
      A_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_q};
      A_IEN:    rd_mux = ien_q;
      A_COUNT:  rd_mux = {{PAD_W{1'b0}}, count};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R10: no kick or clear is produced during the reset pulse
  a_r10_no_sw_in_pulse: assert property (@(posedge clk) disable iff (rst)
    pulsing |-> !kick && !clr);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W       = 16,
  parameter int RELOAD_INIT = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             frozen,
  input  logic             kick,
  input  logic             restore,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] INIT_VAL = CNT_W'(RELOAD_INIT);

  logic advance;

  always_comb begin
    advance = tick && !halt && !frozen && !kick;
    expire  = advance && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)            count <= INIT_VAL;
    else if (restore)   count <= INIT_VAL;
    else if (frozen)    count <= count;
    else if (kick)      count <= reload;
    else if (advance)   count <= (count == '0) ? reload : count - 1'b1;
  end

  a_r1_decrement: assert property (@(posedge clk) disable iff (rst)
    advance && count != '0 |=> count == $past(count) - 1'b1);
  a_r1_expiry_reload: assert property (@(posedge clk) disable iff (rst)
    expire |=> count == $past(reload));
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halt && !kick && !restore |=> $stable(count));
  a_r8_kick_reload: assert property (@(posedge clk) disable iff (rst)
    kick && !frozen && !restore |=> count == $past(reload));
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    frozen && !restore |=> $stable(count));
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  input  logic loc_en,
  input  logic glb_en,
  output logic flag,
  output logic irq,
  output logic sys_reset,
  output logic pulsing,
  output logic restore
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [PW-1:0] pcnt;

  assign pulsing = (pcnt != '0);
  assign restore = (pcnt == PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag      <= 1'b0;
      pcnt      <= '0;
      sys_reset <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= flag && loc_en && glb_en;
      if (restore) begin
        flag      <= 1'b0;
        pcnt      <= '0;
        sys_reset <= 1'b0;
      end else if (pulsing) begin
        pcnt <= pcnt - 1'b1;
      end else if (expire) begin
        if (flag) begin
          pcnt      <= PW'(RST_LEN);
          sys_reset <= 1'b1;
        end else begin
          flag <= 1'b1;
        end
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  a_r2_first_expiry: assert property (@(posedge clk) disable iff (rst)
    expire && !flag && !pulsing |=> flag && !sys_reset);
  a_r3_second_expiry: assert property (@(posedge clk) disable iff (rst)
    expire && flag && !pulsing |=> sys_reset);
  a_r4_restore_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_reset) |-> !flag);
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr && !expire && !pulsing |=> !flag);
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag) && $past(loc_en) && $past(glb_en));
endmodule

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RELOAD_INIT = 255,
  parameter int RST_LEN     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mgmt_irq,
  output logic              sys_reset
);
  logic             halt, loc_en, glb_en, kick, clr;
  logic             flag, pulsing, restore, expire;
  logic [CNT_W-1:0] reload, count;

  wdt_regs #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag(flag), .count(count), .pulsing(pulsing),
    .halt(halt), .loc_en(loc_en), .glb_en(glb_en), .reload(reload),
    .kick(kick), .clr(clr), .rdata(reg_rdata)
  );

  wdt_count #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt), .frozen(pulsing),
    .kick(kick), .restore(restore), .reload(reload),
    .count(count), .expire(expire)
  );

  wdt_stage #(.RST_LEN(RST_LEN)) u_stage (
    .clk(clk), .rst(rst), .expire(expire), .clr(clr),
    .loc_en(loc_en), .glb_en(glb_en), .flag(flag), .irq(mgmt_irq),
    .sys_reset(sys_reset), .pulsing(pulsing), .restore(restore)
  );
endmodule

// File: tb/dual_expiry_wdt_test.sv
module dual_expiry_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int INIT       = 30;
  localparam int RLEN       = 16;

  logic        clk = 0, rst = 1, tick = 0, reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mgmt_irq, sys_reset;

  dual_expiry_wdt #(.CNT_W(CNT_W), .RELOAD_INIT(INIT), .RST_LEN(RLEN)) uut (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mgmt_irq(mgmt_irq),
    .sys_reset(sys_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, pulses = 0, run_len = 0;
  int tick_div = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int m_count, m_reload, m_flag, m_pcnt, m_rst, m_irq;
  logic [31:0] m_ctrl, m_ien, m_rdata;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_count = INIT; m_reload = INIT; m_flag = 0; m_pcnt = 0; m_rst = 0;
      m_irq = 0; m_ctrl = 0; m_ien = 0; m_rdata = 0;
    end else begin
      bit halted, kk, cl, pul, exp_now;
      case (reg_addr)
        3'd0: m_rdata = m_ctrl;
        3'd1: m_rdata = 32'(m_flag);
        3'd2: m_rdata = 32'(m_reload);
        3'd3: m_rdata = m_ien;
        3'd5: m_rdata = 32'(m_count);
        default: m_rdata = 0;
      endcase
      m_irq = (m_flag != 0) && m_ien[13] && m_ien[0];
      halted = m_ctrl[11];
      pul = (m_pcnt != 0);
      kk = reg_wr && reg_addr == 3'd4 && !pul;
      cl = reg_wr && reg_addr == 3'd1 && reg_wdata[0] && !pul;
      if (pul) begin
        if (m_pcnt == 1) begin m_rst = 0; m_count = INIT; m_flag = 0; end
        m_pcnt--;
      end else begin
        exp_now = tick && !halted && !kk && m_count == 0;
        if (kk) m_count = m_reload;
        else if (tick && !halted) m_count = (m_count == 0) ? m_reload : m_count - 1;
        if (exp_now && m_flag == 0) m_flag = 1;
        else if (exp_now) begin m_pcnt = RLEN; m_rst = 1; end
        else if (cl) m_flag = 0;
      end
      if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_ien = reg_wdata;
      if (reg_wr && reg_addr == 3'd2) m_reload = int'(reg_wdata[CNT_W-1:0]);
    end
  end

  // per-cycle comparison and pulse-length monitor
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 irq", {31'b0, mgmt_irq}, 32'(m_irq));
      chk("R3 sys_reset", {31'b0, sys_reset}, 32'(m_rst));
      chk("R9 rdata", reg_rdata, m_rdata);
      if (sys_reset) run_len++;
      else if (run_len != 0) begin
        pulses++;
        chk("R3 pulse length", 32'(run_len), 32'(RLEN));
        run_len = 0;
      end
    end
    tick = (tick_div != 0) && (cyc % tick_div == 0);
  end

  // watchdog
  always @(posedge clk) if (cyc > 100000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); #1 d = reg_rdata;
  endtask

  task automatic wait_flag(int lim);
    logic [31:0] v;
    for (int i = 0; i < lim; i++) begin
      rd(3'd1, v);
      if (v[0]) return;
    end
  endtask

  logic [31:0] v, v2;
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    rd(3'd5, v); chk("R1 init count", v, INIT);
    rd(3'd1, v); chk("R9 status after reset", v, 0);
    chk("R3 no reset at start", {31'b0, sys_reset}, 0);
    chk("R6 no irq at start", {31'b0, mgmt_irq}, 0);
    // first expiry
    wr(3'd2, 5); wr(3'd3, 32'h2001); wr(3'd4, 0);
    rd(3'd5, v); chk("R8 kick reload", v, 5);
    tick_div = 1;
    wait_flag(40);
    tick_div = 0;
    rd(3'd1, v); chk("R2 flag after first expiry", v, 1);
    chk("R2 no reset on first expiry", {31'b0, sys_reset}, 0);
    chk("R6 irq with both enables", {31'b0, mgmt_irq}, 1);
    // write 0 has no effect
    wr(3'd1, 0); rd(3'd1, v); chk("R5 write 0 keeps flag", v, 1);
    wr(3'd3, 32'h0001); repeat (2) @(negedge clk);
    chk("R6 local enable off", {31'b0, mgmt_irq}, 0);
    wr(3'd3, 32'h2000); repeat (2) @(negedge clk);
    chk("R6 global enable off", {31'b0, mgmt_irq}, 0);
    wr(3'd3, 32'h2001);
    wr(3'd1, 1); rd(3'd1, v); chk("R5 write 1 clears flag", v, 0);
    // cleared flag: next expiry only sets flag again
    tick_div = 1;
    wait_flag(40);
    tick_div = 0;
    chk("R5 clear prevents reset", 32'(pulses), 0);
    // second expiry with flag set
    tick_div = 1;
    for (int i = 0; i < 60 && !sys_reset; i++) @(posedge clk);
    chk("R3 reset asserted", {31'b0, sys_reset}, 1);
    wr(3'd0, 32'h0800);
    rd(3'd5, v); rd(3'd5, v2); chk("R10 count frozen in pulse", v2, v);
    wr(3'd1, 1); rd(3'd1, v); chk("R10 clear ignored in pulse", v, 1);
    for (int i = 0; i < 40 && sys_reset; i++) @(posedge clk);
    @(negedge clk);
    chk("R3 one pulse", 32'(pulses), 1);
    rd(3'd5, v); chk("R4 count restored", v, INIT);
    rd(3'd1, v); chk("R4 flag restored", v, 0);
    // halt
    repeat (10) @(negedge clk);
    rd(3'd5, v); chk("R7 halt holds count", v, INIT);
    wr(3'd4, 0); rd(3'd5, v); chk("R8 kick while halted", v, 5);
    wr(3'd0, 0); repeat (4) @(negedge clk);
    rd(3'd5, v); chk("R1 counting resumes", {31'b0, v != 5}, 1);
    rd(3'd6, v); chk("R9 unmapped reads zero", v, 0);
    tick_div = 0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule